// File: doc/BRIEF.md
# Accumulator Processor Core with Prioritised Interrupts

This block is a small processor core built around one accumulator. Each instruction passes through fetch, decode, operand and execute steps, and every step is a separate clocked state. The fetch moves the program counter into the address register, advances the program counter, captures the memory word into the data register, and then copies that word into the instruction register. The core drives one single-port synchronous word memory. A read returns its data one cycle after the address is presented. Stack pushes and pops use the same port.

The core reads loads from four addressing modes: immediate, direct, indirect (two memory reads) and indexed. It has add, compare, three kinds of jump, an index-set instruction, an interrupt return and a halt. An interrupt request is looked at only once an instruction has finished executing. A request marked low priority is ignored. A high-priority request saves the context on a stack that grows downward and sends the core to a fixed service address. A return instruction restores that context.

Top module: `acc_core`

## Requirements
- R1: While reset is held, `halted` and `memWe` are 0. After release, the first instruction is fetched from address 0.
- R2: An instruction word is split as opcode in bits 15:12, mode in bits 11:10 and operand in bits 9:0. Opcodes are 0 load, 1 add, 2 compare, 3 jump, 4 jump-if-equal, 5 jump-if-not-equal, 6 set-index, 7 interrupt-return and 15 halt. A halt placed at address 0 raises `halted` exactly five clock edges after reset release.
- R3: Mode 0 (immediate) takes the zero-extended operand field itself as the value.
- R4: Mode 1 (direct) takes the memory word at the operand address.
- R5: Mode 2 (indirect) reads the word at the operand address and uses its low bits as the address of a second read, which supplies the value.
- R6: Mode 3 (indexed) reads the word at the operand address plus the index register. The set-index opcode loads the index register from its mode-selected value.
- R7: Add puts the 16-bit sum in the accumulator and records the carry-out in status bit 1.
- R8: Compare records accumulator equality in status bit 0. Jump-if-equal and jump-if-not-equal branch on that bit, and fall through otherwise.
- R9: An unconditional jump continues execution at the operand address.
- R10: The halt opcode holds `halted` at 1 until reset. A halted core performs no memory writes and ignores interrupt requests.
- R11: A high-priority request seen at an instruction boundary, outside a service routine, writes four consecutive words to addresses 1023, 1022, 1021 and 1020. These are, in order, the next PC, the accumulator, the index register, and the status word (bit 1 carry, bit 0 equal). Execution then continues at address 512.
- R12: A request with `irqHigh` low is never taken, and the program runs as if no request were present.
- R13: Interrupt-return pops status, index, accumulator and PC in that order. The interrupted program then resumes at the saved PC with its registers and flags intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | 10 | Memory word address |
| memWe | output | 1 | Memory write strobe |
| memWrData | output | 16 | Word to write |
| memRdData | input | 16 | Read word, valid one cycle after its address |
| irqReq | input | 1 | Interrupt request level |
| irqHigh | input | 1 | Request priority, 1 = high |
| halted | output | 1 | Core has executed halt |
| accOut | output | 16 | Accumulator contents |

## Verification
The bench uses the default parameters: a 16-bit word, which leaves a 10-bit address, a service routine at address 512 and a stack top at 1023. Because the word is 16 bits, a single add of 1 to 0xFFFF produces a carry and a zero result. The service routine and the four stack words sit far above the short test programs, so any misplaced push or pop shows up as a wrong final accumulator, never as a corrupted program. The index, equal flag and accumulator are each changed inside the service routine, so each restore is observed separately through a branch or an indexed add after the return.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam logic [3:0] OP_LOAD  = 4'd0;
  localparam logic [3:0] OP_ADD   = 4'd1;
  localparam logic [3:0] OP_CMP   = 4'd2;
  localparam logic [3:0] OP_JMP   = 4'd3;
  localparam logic [3:0] OP_JEQ   = 4'd4;
  localparam logic [3:0] OP_JNE   = 4'd5;
  localparam logic [3:0] OP_SETIX = 4'd6;
  localparam logic [3:0] OP_RTI   = 4'd7;
  localparam logic [3:0] OP_END   = 4'd15;

  localparam logic [1:0] MODE_IMM = 2'd0;
  localparam logic [1:0] MODE_DIR = 2'd1;
  localparam logic [1:0] MODE_IND = 2'd2;
  localparam logic [1:0] MODE_IDX = 2'd3;

  typedef enum logic [1:0] {ADDR_MAR, ADDR_SP, ADDR_SPUP} addr_sel_e;

  typedef enum logic [3:0] {
    S_FMAR, S_FINC, S_FMDR, S_FCIR, S_DEC, S_MRD, S_MCAP, S_MIND,
    S_EXEC, S_ICHK, S_PUSH, S_POPRD, S_POPCAP, S_HALT
  } state_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic      marFromPc;
    logic      marFromEa;
    logic      marFromMdr;
    logic      pcInc;
    logic      pcJump;
    logic      pcIsr;
    logic      mdrLoad;
    logic      cirLoad;
    logic      execute;
    logic      stackWe;
    logic      spDec;
    logic      spInc;
    logic      popLoad;
    addr_sel_e addrSel;
    logic [1:0] stackIdx;   // 0 pc, 1 acc, 2 ix, 3 status
  } ctrl_t;

endpackage

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 10,
  parameter int ISR_ADDR  = 512,
  parameter int STACK_TOP = 1023
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  output logic [3:0]        opcode,
  output logic [1:0]        mode,
  output logic              flagEq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] accOut
);

  localparam int EXT_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc, mar, sp;
  logic [DATA_W-1:0] mdr, cir, acc, ix;
  logic              flagCarry;

  logic [ADDR_W-1:0] opnd, effAddr;
  logic [DATA_W-1:0] srcVal, statusWord;
  logic [DATA_W:0]   sum;

  assign opcode = cir[DATA_W-1 -: 4];
  assign mode   = cir[ADDR_W +: 2];
  assign opnd   = cir[ADDR_W-1:0];
  assign accOut = acc;

  assign srcVal     = (mode == MODE_IMM) ? {{EXT_W{1'b0}}, opnd} : mdr;
  assign effAddr    = (mode == MODE_IDX) ? opnd + ix[ADDR_W-1:0] : opnd;
  assign sum        = {1'b0, acc} + {1'b0, srcVal};
  assign statusWord = {{(DATA_W-2){1'b0}}, flagCarry, flagEq};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc        <= '0;
      mar       <= '0;
      sp        <= ADDR_W'(STACK_TOP);
      mdr       <= '0;
      cir       <= '0;
      acc       <= '0;
      ix        <= '0;
      flagEq    <= 1'b0;
      flagCarry <= 1'b0;
    end else begin
      if (ctrl.marFromPc)  mar <= pc;
      if (ctrl.marFromEa)  mar <= effAddr;
      if (ctrl.marFromMdr) mar <= mdr[ADDR_W-1:0];
      if (ctrl.pcInc)      pc  <= pc + 1'b1;
      if (ctrl.pcJump)     pc  <= opnd;
      if (ctrl.pcIsr)      pc  <= ADDR_W'(ISR_ADDR);
      if (ctrl.mdrLoad)    mdr <= memRdData;
      if (ctrl.cirLoad)    cir <= mdr;
      if (ctrl.spDec)      sp  <= sp - 1'b1;
      if (ctrl.spInc)      sp  <= sp + 1'b1;
      if (ctrl.execute) begin
        case (opcode)
          OP_LOAD:  acc <= srcVal;
          OP_ADD:   {flagCarry, acc} <= sum;
          OP_CMP:   flagEq <= (acc == srcVal);
          OP_SETIX: ix <= srcVal;
          default:  ;
        endcase
      end
      if (ctrl.popLoad) begin
        case (ctrl.stackIdx)
          2'd0:    pc  <= memRdData[ADDR_W-1:0];
          2'd1:    acc <= memRdData;
          2'd2:    ix  <= memRdData;
          default: {flagCarry, flagEq} <= memRdData[1:0];
        endcase
      end
    end
  end

  always_comb begin
    case (ctrl.addrSel)
      ADDR_SP:   memAddr = sp;
      ADDR_SPUP: memAddr = sp + 1'b1;
      default:   memAddr = mar;
    endcase
    case (ctrl.stackIdx)
      2'd0:    memWrData = {{EXT_W{1'b0}}, pc};
      2'd1:    memWrData = acc;
      2'd2:    memWrData = ix;
      default: memWrData = statusWord;
    endcase
  end

  assign memWe = ctrl.stackWe;

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       irqReq,
  input  logic       irqHigh,
  input  logic [3:0] opcode,
  input  logic [1:0] mode,
  input  logic       flagEq,
  output ctrl_t      ctrl,
  output logic       halted
);

  state_e     state, nextState;
  logic [1:0] idx;
  logic       indPending, inService;
  logic       takeIrq, memOperand;

  assign takeIrq    = irqReq && irqHigh && !inService;
  assign memOperand = (opcode == OP_LOAD || opcode == OP_ADD ||
                       opcode == OP_CMP  || opcode == OP_SETIX) && (mode != MODE_IMM);
  assign halted     = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_FMAR;
      idx        <= '0;
      indPending <= 1'b0;
      inService  <= 1'b0;
    end else begin
      state <= nextState;
      case (state)
        S_DEC: begin
          if (opcode == OP_RTI) idx <= 2'd3;
          indPending <= memOperand && (mode == MODE_IND);
        end
        S_MIND: indPending <= 1'b0;
        S_ICHK: if (takeIrq) begin
          idx       <= 2'd0;
          inService <= 1'b1;
        end
        S_PUSH:   idx <= idx + 1'b1;
        S_POPCAP: begin
          idx <= idx - 1'b1;
          if (idx == 2'd0) inService <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrl      = '0;
    nextState = state;
    case (state)
      S_FMAR: begin ctrl.marFromPc = 1'b1; nextState = S_FINC; end
      S_FINC: begin ctrl.pcInc = 1'b1; nextState = S_FMDR; end
      S_FMDR: begin ctrl.mdrLoad = 1'b1; nextState = S_FCIR; end
      S_FCIR: begin ctrl.cirLoad = 1'b1; nextState = S_DEC; end
      S_DEC: begin
        if (opcode == OP_END)      nextState = S_HALT;
        else if (opcode == OP_RTI) nextState = S_POPRD;
        else if (memOperand) begin
          ctrl.marFromEa = 1'b1;
          nextState      = S_MRD;
        end else nextState = S_EXEC;
      end
      S_MRD:  nextState = S_MCAP;
      S_MCAP: begin
        ctrl.mdrLoad = 1'b1;
        nextState    = indPending ? S_MIND : S_EXEC;
      end
      S_MIND: begin ctrl.marFromMdr = 1'b1; nextState = S_MRD; end
      S_EXEC: begin
        ctrl.execute = 1'b1;
        ctrl.pcJump  = (opcode == OP_JMP) ||
                       (opcode == OP_JEQ && flagEq) ||
                       (opcode == OP_JNE && !flagEq);
        nextState    = S_ICHK;
      end
      S_ICHK: nextState = takeIrq ? S_PUSH : S_FMAR;
      S_PUSH: begin
        ctrl.stackWe  = 1'b1;
        ctrl.spDec    = 1'b1;
        ctrl.addrSel  = ADDR_SP;
        ctrl.stackIdx = idx;
        if (idx == 2'd3) begin
          ctrl.pcIsr = 1'b1;
          nextState  = S_FMAR;
        end
      end
      S_POPRD: begin
        ctrl.addrSel = ADDR_SPUP;
        ctrl.spInc   = 1'b1;
        nextState    = S_POPCAP;
      end
      S_POPCAP: begin
        ctrl.popLoad  = 1'b1;
        ctrl.stackIdx = idx;
        nextState     = (idx == 2'd0) ? S_ICHK : S_POPRD;
      end
      default: nextState = S_HALT;
    endcase
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ISR_ADDR  = 512,
  parameter int STACK_TOP = 1023
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [DATA_W-7:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              irqReq,
  input  logic              irqHigh,
  output logic              halted,
  output logic [DATA_W-1:0] accOut
);

  localparam int ADDR_W = DATA_W - 6;

  ctrl_t      ctrl;
  logic [3:0] opcode;
  logic [1:0] mode;
  logic       flagEq;

  acc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqHigh(irqHigh),
    .opcode(opcode), .mode(mode), .flagEq(flagEq),
    .ctrl(ctrl), .halted(halted)
  );

  acc_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .ISR_ADDR(ISR_ADDR), .STACK_TOP(STACK_TOP)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .opcode(opcode), .mode(mode), .flagEq(flagEq),
    .memAddr(memAddr), .memWe(memWe), .memWrData(memWrData),
    .memRdData(memRdData), .accOut(accOut)
  );

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWe,
  input logic              halted
);

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  assert_no_write_halted_R10: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !memWe);

  assert_push_burst_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |=> memWe);

  assert_push_descends_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> (memAddr == ADDR_W'($past(memAddr) - 1'b1)));

  assert_push_length_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(memWe, 1) && $past(memWe, 2) && $past(memWe, 3) && $past(memWe, 4)) |-> !memWe);

endmodule

bind acc_core acc_core_chk #(.ADDR_W(DATA_W - 6)) i_acc_core_chk (
  .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWe(memWe), .halted(halted)
);

// File: tb/test_acc_core.sv
module test_acc_core;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int ADDR_W = DATA_W - 6;
  localparam int MEM_DEPTH = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic              memWe;
  logic [DATA_W-1:0] memWrData;
  logic [DATA_W-1:0] memRdData = '0;
  logic              irqReq = 1'b0;
  logic              irqHigh = 1'b0;
  logic              halted;
  logic [DATA_W-1:0] accOut;

  logic [DATA_W-1:0] mem [MEM_DEPTH];
  logic [ADDR_W-1:0] wrAddrLog [16];
  logic [DATA_W-1:0] wrDataLog [16];
  int wrCount = 0;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core #(.DATA_W(DATA_W), .ISR_ADDR(512), .STACK_TOP(1023)) i_acc_core (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWe(memWe),
    .memWrData(memWrData), .memRdData(memRdData), .irqReq(irqReq),
    .irqHigh(irqHigh), .halted(halted), .accOut(accOut)
  );

  always @(posedge clk) begin
    if (memWe) begin
      mem[memAddr] <= memWrData;
      if (wrCount < 16) begin
        wrAddrLog[wrCount] <= memAddr;
        wrDataLog[wrCount] <= memWrData;
      end
      wrCount <= wrCount + 1;
    end
    memRdData <= mem[memAddr];
  end

  function automatic logic [15:0] enc(logic [3:0] op, logic [1:0] md, int opnd);
    return {op, md, 10'(opnd)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < MEM_DEPTH; i++) mem[i] = '0;
  endtask

  task automatic enterReset();
    @(negedge clk);
    rstN = 1'b0;
    irqReq = 1'b0;
    irqHigh = 1'b0;
    @(negedge clk);
    clearMem();
  endtask

  task automatic runToHalt(string req);
    int n = 0;
    @(negedge clk);
    rstN = 1'b1;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check({req, " halt reached"}, 32'(halted), 32'd1);
  endtask

  task automatic testReset();
    enterReset();
    mem[0] = enc(4'd15, 2'd0, 0);
    check("R1 halted in reset", 32'(halted), 32'd0);
    check("R1 memWe in reset", 32'(memWe), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 first fetch address", 32'(memAddr), 32'd0);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check("R2 not halted after 4 edges", 32'(halted), 32'd0);
    @(negedge clk);
    check("R2 halted after 5 edges", 32'(halted), 32'd1);
  endtask

  task automatic testImmediate();
    enterReset();
    mem[0] = enc(4'd0, 2'd0, 10'h155);
    mem[1] = enc(4'd15, 2'd0, 0);
    runToHalt("R3");
    check("R3 immediate load", 32'(accOut), 32'h155);
  endtask

  task automatic testDirect();
    enterReset();
    mem[0] = enc(4'd0, 2'd1, 100);
    mem[1] = enc(4'd15, 2'd0, 0);
    mem[100] = 16'hBEEF;
    runToHalt("R4");
    check("R4 direct load", 32'(accOut), 32'hBEEF);
  endtask

  task automatic testIndirect();
    enterReset();
    mem[0] = enc(4'd0, 2'd2, 100);
    mem[1] = enc(4'd15, 2'd0, 0);
    mem[100] = 16'd200;
    mem[200] = 16'h1234;
    runToHalt("R5");
    check("R5 indirect load", 32'(accOut), 32'h1234);
  endtask

  task automatic testIndexed();
    enterReset();
    mem[0] = enc(4'd6, 2'd0, 5);
    mem[1] = enc(4'd0, 2'd3, 300);
    mem[2] = enc(4'd15, 2'd0, 0);
    mem[300] = 16'hDEAD;
    mem[305] = 16'h0A0A;
    runToHalt("R6");
    check("R6 indexed load", 32'(accOut), 32'h0A0A);
  endtask

  task automatic testAdd();
    enterReset();
    mem[0] = enc(4'd0, 2'd1, 50);
    mem[1] = enc(4'd1, 2'd0, 2);
    mem[2] = enc(4'd1, 2'd1, 51);
    mem[3] = enc(4'd15, 2'd0, 0);
    mem[50] = 16'hFFFF;
    mem[51] = 16'h0100;
    runToHalt("R7");
    check("R7 add wraps then direct add", 32'(accOut), 32'h0101);
  endtask

  task automatic testBranch(logic [3:0] jop, int cmpVal, logic [15:0] expAcc, string tag);
    enterReset();
    mem[0] = enc(4'd0, 2'd0, 7);
    mem[1] = enc(4'd2, 2'd0, cmpVal);
    mem[2] = enc(jop, 2'd0, 10);
    mem[3] = enc(4'd0, 2'd0, 3);
    mem[4] = enc(4'd15, 2'd0, 0);
    mem[10] = enc(4'd0, 2'd0, 2);
    mem[11] = enc(4'd15, 2'd0, 0);
    runToHalt("R8");
    check(tag, 32'(accOut), 32'(expAcc));
  endtask

  task automatic testJump();
    enterReset();
    mem[0] = enc(4'd3, 2'd0, 20);
    mem[1] = enc(4'd0, 2'd0, 1);
    mem[2] = enc(4'd15, 2'd0, 0);
    mem[20] = enc(4'd0, 2'd0, 9);
    mem[21] = enc(4'd15, 2'd0, 0);
    runToHalt("R9");
    check("R9 unconditional jump", 32'(accOut), 32'd9);
  endtask

  task automatic testHaltIgnoresIrq();
    int base;
    enterReset();
    mem[0] = enc(4'd0, 2'd0, 4);
    mem[1] = enc(4'd15, 2'd0, 0);
    runToHalt("R10");
    base = wrCount;
    irqHigh = 1'b1;
    irqReq = 1'b1;
    repeat (60) @(negedge clk);
    check("R10 no push while halted", 32'(wrCount - base), 32'd0);
    check("R10 still halted", 32'(halted), 32'd1);
    check("R10 acc frozen", 32'(accOut), 32'd4);
    irqReq = 1'b0;
  endtask

  task automatic testLowPriority();
    int base;
    enterReset();
    mem[0] = enc(4'd0, 2'd0, 5);
    mem[1] = enc(4'd1, 2'd0, 1);
    mem[2] = enc(4'd15, 2'd0, 0);
    base = wrCount;
    irqHigh = 1'b0;
    irqReq = 1'b1;
    runToHalt("R12");
    check("R12 low priority no push", 32'(wrCount - base), 32'd0);
    check("R12 program unaffected", 32'(accOut), 32'd6);
  endtask

  task automatic testInterrupt();
    int base;
    int n = 0;
    bit raised = 0;
    bit sawIsr = 0;
    enterReset();
    mem[0]  = enc(4'd6, 2'd0, 3);     // ix = 3
    mem[1]  = enc(4'd0, 2'd1, 60);    // acc = FFFF
    mem[2]  = enc(4'd1, 2'd0, 1);     // acc = 0, carry
    mem[3]  = enc(4'd2, 2'd0, 0);     // eq = 1
    mem[4]  = enc(4'd0, 2'd0, 10'h22);
    mem[5]  = enc(4'd4, 2'd0, 8);     // taken only if eq restored
    mem[6]  = enc(4'd15, 2'd0, 0);
    mem[8]  = enc(4'd1, 2'd0, 1);
    mem[9]  = enc(4'd1, 2'd3, 40);    // adds mem[40+ix]
    mem[10] = enc(4'd15, 2'd0, 0);
    mem[43] = 16'h0100;
    mem[49] = 16'h0200;
    mem[60] = 16'hFFFF;
    mem[512] = enc(4'd0, 2'd0, 10'h77);
    mem[513] = enc(4'd6, 2'd0, 9);
    mem[514] = enc(4'd2, 2'd0, 1);
    mem[515] = enc(4'd7, 2'd0, 0);
    base = wrCount;
    irqHigh = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
      if (!raised && accOut == 16'h22) begin
        irqReq = 1'b1;
        raised = 1;
      end
      if (irqReq && wrCount > base) irqReq = 1'b0;
      if (accOut == 16'h77) sawIsr = 1;
    end
    check("R11 halt reached", 32'(halted), 32'd1);
    check("R11 four pushes", 32'(wrCount - base), 32'd4);
    check("R11 push addr 0", 32'(wrAddrLog[base]), 32'd1023);
    check("R11 push addr 3", 32'(wrAddrLog[base+3]), 32'd1020);
    check("R11 pushed pc", 32'(wrDataLog[base]), 32'd5);
    check("R11 pushed acc", 32'(wrDataLog[base+1]), 32'h22);
    check("R11 pushed ix", 32'(wrDataLog[base+2]), 32'd3);
    check("R11 pushed status", 32'(wrDataLog[base+3]), 32'd3);
    check("R11 service routine ran", 32'(sawIsr), 32'd1);
    check("R13 context restored", 32'(accOut), 32'h0123);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    testImmediate();
    testDirect();
    testIndirect();
    testIndexed();
    testAdd();
    testBranch(4'd4, 7, 16'd2, "R8 jeq taken");
    testBranch(4'd5, 7, 16'd3, "R8 jne not taken");
    testBranch(4'd5, 8, 16'd2, "R8 jne taken");
    testBranch(4'd4, 8, 16'd3, "R8 jeq not taken");
    testJump();
    testHaltIgnoresIrq();
    testLowPriority();
    testInterrupt();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule